// File: doc/BRIEF.md
# Machine Status Word and Trap Logic

This block keeps the processor's 4-bit machine status word. It carries out the three control operations that touch that word: load, store (readback) and clear-task-switched. On every instruction strobe it also checks the current word, the current privilege level and the I/O privilege field from the flags register. From these it decides whether a coprocessor-extension instruction, a WAIT instruction or an I/O instruction may go ahead, or whether it must raise an exception and with which vector.

The decoder presents one strobe per instruction with a 3-bit class code. Class codes are: 0 other, 1 load word, 2 store word, 3 clear task-switched, 4 extension instruction, 5 WAIT, 6 I/O, 7 other. Word bit positions are: bit0 protection enable (PE), bit1 monitor extension (MP), bit2 emulate extension (EM), bit3 task switched (TS). The exception request is a one-cycle pulse, registered from the strobe. The vector is held stable beside it.

Top module: `msw_trap_unit`

## Requirements
- R1: After reset the status word reads 0, the protected-mode output is 0 and no exception request is raised.
- R2: A load (class 1) writes bits 3:0 from the write data; readback bits 15:4 always read 0.
- R3: Once PE is 1, a later load with PE=0 leaves PE at 1; only reset clears it.
- R4: A clear-task-switched operation (class 3) forces TS to 0 and leaves PE, MP and EM unchanged.
- R5: An extension instruction (class 4) with EM=1 raises an exception with vector 7.
- R6: An extension instruction with EM=0 raises vector 7 when TS=1 and proceeds when TS=0.
- R7: A WAIT instruction (class 5) raises vector 7 exactly when both MP and TS are 1.
- R8: In protected mode (PE=1), an I/O instruction (class 6) passes when the current privilege level is numerically less than or equal to the I/O privilege level (00 most trusted). Otherwise it raises vector 13.
- R9: In real mode (PE=0), every I/O instruction passes regardless of privilege levels.
- R10: The exception request rises in the cycle after the strobe that caused it and lasts one cycle; a store (class 2) or an other class (0, 7) never raises one.
- R11: Class or data inputs without a strobe change neither the status word nor the exception request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Instruction strobe |
| op_kind_i | input | 3 | Instruction class code |
| wr_data_i | input | 4 | Load data for the status word |
| cpl_i | input | 2 | Current privilege level |
| iopl_i | input | 2 | I/O privilege field (flags bits 13:12) |
| msw_o | output | 16 | Status word readback, upper bits zero |
| pmode_o | output | 1 | Protected mode active (PE) |
| exc_req_o | output | 1 | One-cycle exception request |
| exc_vec_o | output | 8 | Exception vector number |

## Verification
The bench builds the block with its default parameters: a 16-bit readback, 8-bit vectors, and vectors 7 and 13. It reaches all sixteen status-word values by reset and load. For each value it applies the extension, WAIT and I/O classes under all sixteen pairs of privilege levels. This covers the EM/TS ordering, the equal-level I/O boundary and the real-mode bypass. Separate sequences exercise PE stickiness, clear-task-switched, strobe-less inputs and back-to-back traps.

// File: rtl/msw_pkg.sv
package msw_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LMSW  = 3'd1,
    OP_SMSW  = 3'd2,
    OP_CLTS  = 3'd3,
    OP_EXT   = 3'd4,
    OP_WAIT  = 3'd5,
    OP_IO    = 3'd6,
    OP_OTHER = 3'd7
  } op_kind_e;

  localparam int unsigned MSW_W  = 4;
  localparam int unsigned BIT_PE = 0;
  localparam int unsigned BIT_MP = 1;
  localparam int unsigned BIT_EM = 2;
  localparam int unsigned BIT_TS = 3;
endpackage

// File: rtl/msw_reg.sv
module msw_reg
  import msw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  op_kind_e         op_kind_i,
  input  logic [MSW_W-1:0] wr_data_i,
  output logic [MSW_W-1:0] msw_o
);
  logic [MSW_W-1:0] msw_q, msw_d;

  always_comb begin
    msw_d = msw_q;
    if (op_valid_i) begin
      unique case (op_kind_i)
        OP_LMSW: begin
          msw_d = wr_data_i;
          msw_d[BIT_PE] = wr_data_i[BIT_PE] | msw_q[BIT_PE]; // PE is sticky
        end
        OP_CLTS: msw_d[BIT_TS] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msw_q <= '0;
    else         msw_q <= msw_d;
  end

  assign msw_o = msw_q;

  a_r3_pe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msw_q[BIT_PE] |=> msw_q[BIT_PE]);

  a_r4_clts_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_kind_i == OP_CLTS) |=> (!msw_q[BIT_TS] && $stable(msw_q[BIT_EM:BIT_PE])));

  a_r11_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(msw_q));
endmodule

// File: rtl/trap_eval.sv
module trap_eval
  import msw_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned VEC_NM = 7,
  parameter int unsigned VEC_GP = 13
) (
  input  logic             op_valid_i,
  input  op_kind_e         op_kind_i,
  input  logic [MSW_W-1:0] msw_i,
  input  logic [1:0]       cpl_i,
  input  logic [1:0]       iopl_i,
  output logic             trap_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [VEC_W-1:0] NM = VEC_W'(VEC_NM);
  localparam logic [VEC_W-1:0] GP = VEC_W'(VEC_GP);

  always_comb begin
    trap_o = 1'b0;
    vec_o  = '0;
    if (op_valid_i) begin
      unique case (op_kind_i)
        OP_EXT: begin
          // EM checked ahead of TS
          if (msw_i[BIT_EM])      begin trap_o = 1'b1; vec_o = NM; end
          else if (msw_i[BIT_TS]) begin trap_o = 1'b1; vec_o = NM; end
        end
        OP_WAIT: if (msw_i[BIT_MP] && msw_i[BIT_TS]) begin
          trap_o = 1'b1; vec_o = NM;
        end
        OP_IO: if (msw_i[BIT_PE] && (cpl_i > iopl_i)) begin
          trap_o = 1'b1; vec_o = GP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exc_pulse.sv
module exc_pulse #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      vec_o <= '0;
    end else begin
      req_o <= trap_i;
      if (trap_i) vec_o <= vec_i;
    end
  end

  a_r10_vec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_i |=> $stable(vec_o));
endmodule

// File: rtl/msw_trap_unit.sv
module msw_trap_unit
  import msw_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned VEC_NM = 7,
  parameter int unsigned VEC_GP = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_kind_i,
  input  logic [MSW_W-1:0]  wr_data_i,
  input  logic [1:0]        cpl_i,
  input  logic [1:0]        iopl_i,
  output logic [WORD_W-1:0] msw_o,
  output logic              pmode_o,
  output logic              exc_req_o,
  output logic [VEC_W-1:0]  exc_vec_o
);
  localparam int unsigned PAD_W = WORD_W - MSW_W;

  op_kind_e         kind;
  logic [MSW_W-1:0] msw_q;
  logic             trap;
  logic [VEC_W-1:0] trap_vec;

  assign kind = op_kind_e'(op_kind_i);

  msw_reg u_reg (
    .clk_i, .rst_ni, .op_valid_i,
    .op_kind_i (kind),
    .wr_data_i,
    .msw_o     (msw_q)
  );

  trap_eval #(.VEC_W(VEC_W), .VEC_NM(VEC_NM), .VEC_GP(VEC_GP)) u_eval (
    .op_valid_i,
    .op_kind_i (kind),
    .msw_i     (msw_q),
    .cpl_i, .iopl_i,
    .trap_o    (trap),
    .vec_o     (trap_vec)
  );

  exc_pulse #(.VEC_W(VEC_W)) u_pulse (
    .clk_i, .rst_ni,
    .trap_i (trap),
    .vec_i  (trap_vec),
    .req_o  (exc_req_o),
    .vec_o  (exc_vec_o)
  );

  assign msw_o   = {{PAD_W{1'b0}}, msw_q};
  assign pmode_o = msw_q[BIT_PE];

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msw_o[WORD_W-1:MSW_W] == '0);

  a_r9_real_io_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && kind == OP_IO && !pmode_o) |=> !exc_req_o);

  a_r10_req_from_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> $past(op_valid_i));

  a_r10_vec_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (exc_vec_o == VEC_W'(VEC_NM) || exc_vec_o == VEC_W'(VEC_GP)));

  a_r10_no_trap_smsw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && kind == OP_SMSW) |=> !exc_req_o);
endmodule

// File: tb/sim_msw_trap_unit.sv
module sim_msw_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_kind = 3'd0;
  logic [3:0]  wr_data = 4'd0;
  logic [1:0]  cpl = 2'd0;
  logic [1:0]  iopl = 2'd0;
  logic [15:0] msw;
  logic        pmode, exc_req;
  logic [7:0]  exc_vec;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int m_msw = 0;
  int m_req = 0;
  int m_vec = 0;

  always #10 clk = ~clk;

  msw_trap_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_kind_i(op_kind),
    .wr_data_i(wr_data), .cpl_i(cpl), .iopl_i(iopl),
    .msw_o(msw), .pmode_o(pmode), .exc_req_o(exc_req), .exc_vec_o(exc_vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int k, input int m);
    case (k)
      1: return "R2";
      3: return "R4";
      4: return ((m & 4) != 0) ? "R5" : "R6";
      5: return "R7";
      6: return ((m & 1) != 0) ? "R8" : "R9";
      0, 7, 2: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare_all(input string tag);
    chk({tag, " msw"}, int'(msw), m_msw);
    chk({tag, " pmode"}, int'(pmode), m_msw & 1);
    chk({tag, " req"}, int'(exc_req), m_req);
    if (m_req != 0) chk({tag, " vec"}, int'(exc_vec), m_vec);
  endtask

  // one clock: drive at negedge, model update, compare at next negedge
  task automatic cyc(input bit v, input int k, input int d, input int c, input int io);
    int nm, trap, vec;
    string tag;
    op_valid = v; op_kind = 3'(k); wr_data = 4'(d); cpl = 2'(c); iopl = 2'(io);
    nm = m_msw; trap = 0; vec = m_vec;
    tag = v ? tag_of(k, m_msw) : "R11";
    if (v) begin
      if (k == 1) nm = (d & 15) | (m_msw & 1);
      if (k == 3) nm = m_msw & 7;
      if (k == 4 && ((m_msw & 4) != 0 || (m_msw & 8) != 0)) begin trap = 1; vec = 7; end
      if (k == 5 && (m_msw & 2) != 0 && (m_msw & 8) != 0) begin trap = 1; vec = 7; end
      if (k == 6 && (m_msw & 1) != 0 && c > io) begin trap = 1; vec = 13; end
    end
    @(posedge clk);
    @(negedge clk);
    m_msw = nm; m_req = trap; m_vec = vec;
    compare_all(tag);
    op_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0;
    #5;
    m_msw = 0; m_req = 0; m_vec = 0;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    cyc(0, 0, 0, 0, 0);
    // R2 loads in real mode, upper bits zero
    cyc(1, 1, 4'b1110, 0, 0);
    chk("R2 upper", int'(msw[15:4]), 0);
    cyc(1, 2, 0, 0, 0);
    cyc(1, 1, 4'b0110, 0, 0);
    // R4 clear TS
    cyc(1, 1, 4'b1110, 0, 0);
    cyc(1, 3, 0, 0, 0);
    // R3 PE stickiness
    cyc(1, 1, 4'b1011, 0, 0);
    cyc(1, 1, 4'b0000, 0, 0);
    chk("R3 pe", int'(pmode), 1);
    cyc(1, 3, 0, 0, 0);
    // R11 no strobe: kinds/data ignored
    cyc(0, 1, 4'b1110, 3, 0);
    cyc(0, 6, 0, 3, 0);
    cyc(0, 4, 0, 0, 0);
    // R10 back-to-back I/O traps, then single pulse ends
    cyc(1, 6, 0, 3, 0);
    cyc(1, 6, 0, 2, 1);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 7, 0, 3, 0);
    cyc(1, 0, 0, 3, 0);
    do_reset();
    chk("R3 reset clears pe", int'(pmode), 0);
    // exhaustive sweep
    for (int m = 0; m < 16; m++) begin
      do_reset();
      cyc(1, 1, m, 0, 0);
      for (int k = 4; k <= 6; k++)
        for (int p = 0; p < 16; p++) begin
          cyc(1, k, 0, p >> 2, p & 3);
          cyc(0, 0, 0, 0, 0);
        end
      cyc(1, 2, 0, 3, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule